// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block is the digital control core of a multi-channel sampling converter. It decides which analog input is converted in each conversion frame. A frame opens when the chip-select line falls and closes when it rises again. A serial front end, outside this block, hands over decoded register words. A word is either a control word or, when one was announced, a channel bitmap for the shadow register. The block keeps track of the active sequencing program and drives the channel number for the current frame.

The block also manages an automatic shutdown power mode. In this mode the converter is powered down at the end of each valid frame. The next chip-select falling edge wakes it, and a parameterised wake-up interval must pass before a frame counts as valid. Frames that arrive while the converter is down or still waking do not advance the channel sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `cur_ch` is 0, `pwr_down` is 0 and `conv_ready` is 1. The block is in direct addressing with the converter fully powered.
- R2: Control word layout with the default parameters: bits [2:0] hold the channel address, bit 3 the shadow-select flag, bit 4 the sequence flag and bits [6:5] the power field. Bit 7 is ignored. A control word with both flags at 0 selects direct mode. Every later valid frame then converts the address carried by the most recent such word. `cur_ch` changes on the first clock edge that samples `cs_n` low.
- R3: A control word with sequence 0 and shadow-select 1 makes the next write a channel bitmap, where bit i selects channel i. Valid frames then step through the set bits from lowest to highest, skip clear bits, and wrap back to the lowest.
- R4: After a bitmap load, or after a control word with both flags at 1, the next valid frame starts the new program at its first channel. That is the lowest set bit for a bitmap and 0 for a sweep.
- R5: A control word with sequence 1 and shadow-select 0 changes neither the running program nor its position. Only its power field takes effect.
- R6: A control word with both flags at 1 sweeps valid frames through channels 0, 1, …, n and back to 0, where n is the address field of that word.
- R7: An all-zero bitmap makes every valid frame convert channel 0.
- R8: With the upper power-field bit at 0 (auto shutdown), `pwr_down` rises on the clock edge that samples `cs_n` high at the end of a valid frame.
- R9: A `cs_n` falling edge while powered down clears `pwr_down` and holds `conv_ready` low for exactly WAKE_CYC clock edges. That frame, and any frame started while `conv_ready` is low, leaves `cur_ch` unchanged and does not cause a shutdown at its end.
- R10: With the power field at 11, the converter never powers down. Writing 11 while it is powered down clears `pwr_down` on the following clock edge and starts the wake interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe for a decoded register write |
| wr_data | input | WORD_W | Control word, or channel bitmap after a shadow-select word |
| cs_n | input | 1 | Chip select; falling edge opens a frame, rising edge closes it |
| cur_ch | output | ADDR_W | Channel converted in the current frame |
| pwr_down | output | 1 | Power-down request to the analog core |
| conv_ready | output | 1 | High when a frame starting now would be valid |

## Verification
`cur_ch` settles one clock edge after `cs_n` is driven low. The driver lowers `cs_n` on a falling clock edge and signals the monitor exactly one falling edge later, and the monitor compares against the queued channel at that point. `pwr_down` follows the edge that samples `cs_n` high, so the power checks read it two falling edges after the rise. `conv_ready` is sampled WAKE_CYC−1 and WAKE_CYC falling edges after the waking edge, which fixes the length of the wake window to the cycle. A write takes effect on the next rising edge, and no frame is driven until the write strobe has dropped.

// File: rtl/adc_seq_pkg.sv
// Shared types for the channel sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package adc_seq_pkg;

    // Active channel-selection program
    typedef enum logic [1:0] {
        SM_DIRECT = 2'd0,
        SM_SHADOW = 2'd1,
        SM_SWEEP  = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/adc_seq_regs.sv
// Control-word decoder and program state.
// Holds the active mode, address, bitmap, power setting and a restart
// flag that tells the channel unit to begin a new program.
// Assumes wr_valid is a single-cycle strobe.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_valid,
    output seq_mode_e         mode_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NUM_CH-1:0] map_o,
    output logic              pm_auto_o,
    output logic              restart_o
);

    localparam int SHD_POS = ADDR_W;
    localparam int SEQ_POS = ADDR_W + 1;
    localparam int PM_HI   = ADDR_W + 3;

    seq_mode_e         mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NUM_CH-1:0] map_q;
    logic              pm_hi_q;
    logic              want_map_q;
    logic              restart_q;

    // Decode writes and retire the restart flag on the first valid frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= SM_DIRECT;
            addr_q     <= '0;
            map_q      <= '0;
            pm_hi_q    <= 1'b1;
            want_map_q <= 1'b0;
            restart_q  <= 1'b0;
        end else begin
            if (frame_valid)
                restart_q <= 1'b0;
            if (wr_valid) begin
                if (want_map_q) begin
                    map_q      <= wr_data[NUM_CH-1:0];
                    mode_q     <= SM_SHADOW;
                    restart_q  <= 1'b1;
                    want_map_q <= 1'b0;
                end else begin
                    pm_hi_q <= wr_data[PM_HI];
                    case ({wr_data[SEQ_POS], wr_data[SHD_POS]})
                        2'b00: begin
                            mode_q <= SM_DIRECT;
                            addr_q <= wr_data[ADDR_W-1:0];
                        end
                        2'b01: want_map_q <= 1'b1;
                        2'b11: begin
                            mode_q    <= SM_SWEEP;
                            addr_q    <= wr_data[ADDR_W-1:0];
                            restart_q <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign mode_o    = mode_q;
    assign addr_o    = addr_q;
    assign map_o     = map_q;
    assign pm_auto_o = ~pm_hi_q;
    assign restart_o = restart_q;

endmodule

// File: rtl/adc_seq_chan.sv
// Channel selector: computes the channel for the next valid frame and
// registers it into cur_ch. Assumes map/addr are stable during a frame edge.
module adc_seq_chan
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  seq_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] map,
    input  logic              restart,
    output logic [ADDR_W-1:0] cur_ch
);

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] lowest;
    logic [ADDR_W-1:0] upper;
    logic [NUM_CH-1:0] above;

    // Selected channels strictly above the current one
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_above
            assign above[g] = map[g] && (ADDR_W'(g) > cur_q);
        end
    endgenerate

    // Lowest set bit, and the next set bit above cur (wrapping to lowest)
    always_comb begin
        lowest = '0;
        for (int i = NUM_CH - 1; i >= 0; i--)
            if (map[i]) lowest = ADDR_W'(i);
        upper = lowest;
        for (int i = NUM_CH - 1; i >= 0; i--)
            if (above[i]) upper = ADDR_W'(i);
    end

    // Next channel per active program
    always_comb begin
        case (mode)
            SM_SWEEP:  nxt = (restart || cur_q >= addr) ? '0 : cur_q + 1'b1;
            SM_SHADOW: nxt = (map == '0) ? '0 : (restart ? lowest : upper);
            default:   nxt = addr;
        endcase
    end

    // Advance only on valid frames
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (frame_valid)
            cur_q <= nxt;
    end

    assign cur_ch = cur_q;

endmodule

// File: rtl/adc_seq_power.sv
// Auto-shutdown and wake-up timer. Powers down at the close of a valid
// frame in auto mode; wakes on the next frame start or on a switch to
// full power, then holds ready low for WAKE_CYC edges.
module adc_seq_power #(
    parameter int WAKE_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic frame_valid,
    input  logic pm_auto,
    output logic pwr_down,
    output logic conv_ready
);

    localparam int TW = $clog2(WAKE_CYC + 1);

    logic          down_q;
    logic [TW-1:0] timer_q;
    logic          act_q;

    // Shutdown / wake sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q  <= 1'b0;
            timer_q <= '0;
            act_q   <= 1'b0;
        end else if (down_q) begin
            act_q <= 1'b0;
            if (cs_fall || !pm_auto) begin
                down_q  <= 1'b0;
                timer_q <= TW'(WAKE_CYC);
            end
        end else begin
            if (timer_q != '0)
                timer_q <= timer_q - 1'b1;
            if (frame_valid)
                act_q <= 1'b1;
            else if (cs_rise) begin
                act_q <= 1'b0;
                if (act_q && pm_auto)
                    down_q <= 1'b1;
            end
        end
    end

    assign pwr_down   = down_q;
    assign conv_ready = !down_q && (timer_q == '0);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the channel sequencer: chip-select edge detection plus the
// register, channel and power units. Assumes cs_n is synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int ADDR_W   = $clog2(NUM_CH),
    parameter int WORD_W   = 8,
    parameter int WAKE_CYC = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cs_n,
    output logic [ADDR_W-1:0] cur_ch,
    output logic              pwr_down,
    output logic              conv_ready
);

    logic              cs_q;
    logic              cs_fall;
    logic              cs_rise;
    logic              frame_valid;
    seq_mode_e         mode;
    logic [ADDR_W-1:0] addr_q;
    logic [NUM_CH-1:0] map_q;
    logic              pm_auto;
    logic              restart;

    // Previous chip-select level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    assign cs_fall     = cs_q & ~cs_n;
    assign cs_rise     = ~cs_q & cs_n;
    assign frame_valid = cs_fall & conv_ready;

    adc_seq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .frame_valid(frame_valid), .mode_o(mode), .addr_o(addr_q),
        .map_o(map_q), .pm_auto_o(pm_auto), .restart_o(restart)
    );

    adc_seq_chan #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .mode(mode),
        .addr(addr_q), .map(map_q), .restart(restart), .cur_ch(cur_ch)
    );

    adc_seq_power #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .frame_valid(frame_valid), .pm_auto(pm_auto),
        .pwr_down(pwr_down), .conv_ready(conv_ready)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for the channel sequencer, bound into the top module.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid,
    input seq_mode_e         mode,
    input logic [ADDR_W-1:0] addr_q,
    input logic [NUM_CH-1:0] map_q,
    input logic              restart,
    input logic              pm_auto,
    input logic [ADDR_W-1:0] cur_ch,
    input logic              pwr_down,
    input logic              conv_ready
);

    assert_direct_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && mode == SM_DIRECT |=> cur_ch == $past(addr_q));

    assert_shadow_member_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && mode == SM_SHADOW && map_q != '0
        |=> (($past(map_q) >> cur_ch) & NUM_CH'(1)) != '0);

    assert_sweep_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && mode == SM_SWEEP && restart |=> cur_ch == '0);

    assert_sweep_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && mode == SM_SWEEP |=> cur_ch <= $past(addr_q));

    assert_empty_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && mode == SM_SHADOW && map_q == '0 |=> cur_ch == '0);

    assert_ready_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !conv_ready);

    assert_hold_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(cur_ch));

    assert_stay_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_auto && !pwr_down |=> !pwr_down);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .mode(mode),
    .addr_q(addr_q), .map_q(map_q), .restart(restart), .pm_auto(pm_auto),
    .cur_ch(cur_ch), .pwr_down(pwr_down), .conv_ready(conv_ready)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

    localparam int WAKE = 250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cs_n = 1'b1;
    logic [2:0] cur_ch;
    logic       pwr_down;
    logic       conv_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int exp_q[$];
    string tag_q[$];
    event smp_ev;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.NUM_CH(8), .WORD_W(8), .WAKE_CYC(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .cs_n(cs_n), .cur_ch(cur_ch), .pwr_down(pwr_down), .conv_ready(conv_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl(input bit seq, input bit shd,
                                        input logic [1:0] pm, input logic [2:0] a);
        return {1'b0, pm, seq, shd, a};
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Driver: one frame, queue expected channel, signal monitor
    task automatic frame(input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        ->smp_ev;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare cur_ch against scoreboard head
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(cur_ch), exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cur_ch", int'(cur_ch), 0);
        check("R1 pwr_down", int'(pwr_down), 0);
        check("R1 conv_ready", int'(conv_ready), 1);

        // R2 direct addressing
        wr(ctrl(0, 0, 2'b11, 3'd5));
        frame(5, "R2 direct 5");
        wr(ctrl(0, 0, 2'b11, 3'd2));
        frame(2, "R2 direct 2");
        frame(2, "R2 direct repeat");

        // R3/R4 shadow bitmap channels 2,5,7
        wr(ctrl(0, 1, 2'b11, 3'd0));
        wr(8'b1010_0100);
        frame(2, "R4 shadow first");
        frame(5, "R3 shadow skip");
        frame(7, "R3 shadow top");
        frame(2, "R3 shadow wrap");
        frame(5, "R3 shadow again");

        // R5 hold write keeps position
        wr(ctrl(1, 0, 2'b11, 3'd1));
        frame(7, "R5 hold continues");
        frame(2, "R5 hold wrap");

        // R4 new bitmap restarts at lowest
        wr(ctrl(0, 1, 2'b11, 3'd0));
        wr(8'b0001_0010);
        frame(1, "R4 reload first");
        frame(4, "R3 reload next");
        frame(1, "R3 reload wrap");

        // R7 empty bitmap
        wr(ctrl(0, 1, 2'b11, 3'd0));
        wr(8'h00);
        frame(0, "R7 empty a");
        frame(0, "R7 empty b");

        // R6 sweep 0..3
        wr(ctrl(1, 1, 2'b11, 3'd3));
        frame(0, "R6 sweep 0");
        frame(1, "R6 sweep 1");
        wr(ctrl(1, 0, 2'b11, 3'd7));
        frame(2, "R5 hold in sweep");
        frame(3, "R6 sweep top");
        frame(0, "R6 sweep wrap");
        frame(1, "R6 sweep 1b");
        wr(ctrl(1, 1, 2'b11, 3'd2));
        frame(0, "R4 sweep restart");

        // R8 auto shutdown via hold write
        wr(ctrl(1, 0, 2'b00, 3'd0));
        frame(1, "R8 valid frame");
        check("R8 pwr_down after frame", int'(pwr_down), 1);
        check("R8 not ready", int'(conv_ready), 0);

        // R9 waking frame
        held = int'(cur_ch);
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R9 woken", int'(pwr_down), 0);
        check("R9 waking not ready", int'(conv_ready), 0);
        repeat (WAKE - 1) @(negedge clk);
        check("R9 ready one edge early", int'(conv_ready), 0);
        @(negedge clk);
        check("R9 ready at wake end", int'(conv_ready), 1);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 channel held", int'(cur_ch), held);
        check("R9 no shutdown after waking frame", int'(pwr_down), 0);
        frame(2, "R9 valid after wake");
        check("R8 down again", int'(pwr_down), 1);

        // R10 full power write wakes
        wr(ctrl(1, 0, 2'b11, 3'd0));
        @(negedge clk);
        check("R10 woken by write", int'(pwr_down), 0);
        check("R10 waking", int'(conv_ready), 0);
        repeat (WAKE) @(negedge clk);
        check("R10 ready", int'(conv_ready), 1);
        frame(0, "R10 sweep wrap");
        check("R10 stays up", int'(pwr_down), 0);
        check("R10 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule